// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Output Writes and a Shared Interrupt

This block gives software control of sixteen general-purpose pins through a small word-addressed register bus. Each pin can be switched between input and output. Output levels are updated with a single write that carries both a per-pin write mask and the new data, so no read-modify-write is needed to change one pin. The pin levels are brought through a two-stage synchronizer. Software can read them back from a pin-state register.

The upper eight pins, 8 through 15, also feed one shared, level-sensitive interrupt request. Each of these pins is gated by its own enable bit, and the gated results are ORed together. A parameter selects where those enable bits sit in the enable register. In the packed layout, pin 8+k uses bit k. In the direct layout, pin n uses bit n.

The whole bank is switched on and off through its own control register. Bit 0 runs the local clock enable and bit 1 holds the bank in reset. The bank only operates when this register holds the value 1. In every other state the pins are released to input, the interrupt is held low and register writes are dropped.

Top module: `gpio_bank`

## Requirements
- R1: After the external reset, the control, direction, output-data and interrupt-enable registers all read 0, pin_oe and pin_out are all zero and irq_shared is low.
- R2: The control register is at address 0, and its bits 1:0 read back as written. The bank is active only when the register holds 1 (bit 0 clock enable set, bit 1 reset clear). A write to address 0 is accepted in every state.
- R3: While control bit 1 is set (values 2 or 3), the direction, output-data and interrupt-enable registers are cleared and held at 0, and writes to them are ignored. After returning to 1, they still read 0.
- R4: While the bank is inactive, pin_oe and pin_out are 0, irq_shared is low and the pin-state register reads 0. With value 0 (clock off, no reset), writes to addresses 1, 2 and 4 are ignored, and the stored contents survive a return to 1.
- R5: The direction register is at address 1 and holds one bit per pin (1 = output). It is replaced whole by a write and reads back unchanged. While active, pin_oe equals it.
- R6: The output register is at address 2. A write uses bits 31:16 as per-pin write enables and bits 15:0 as data, and only the pins whose enable bit is 1 take the new data. A read returns the 16 data bits with the upper half 0. While active, pin_out equals it.
- R7: The pin-state register is at address 3. While active, it returns pin_in as seen after two rising clock edges, and a write to it changes nothing. Addresses 5 to 7 read 0 and ignore writes.
- R8: irq_shared is active-high, level-sensitive and needs no acknowledge. While active, it is the OR over pins 8 to 15 of (synchronized pin level AND that pin's enable bit). It follows the pin levels with the same two-edge latency as the pin-state register.
- R9: With IRQ_EN_PACKED = 1, enable bit k gates pin 8+k. With IRQ_EN_PACKED = 0, bit n gates pin n. Bits outside the selected eight are stored but have no effect on irq_shared.
- R10: The interrupt-enable register is at address 4. It stores and reads back all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_wdata | input | 32 | Write data (mask in 31:16 for the output register) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Levels present on the pins |
| pin_out | output | 16 | Output data driven to the pins |
| pin_oe | output | 16 | Per-pin output enable (1 = drive) |
| irq_shared | output | 1 | Shared interrupt request of pins 8 to 15 |

## Verification
Control state that is wrong shows up at once, on the clock edge after the control write. A bank that wrongly believes it is active keeps pin_oe or irq_shared up while they should be released. A bank that wrongly believes it is inactive reads 0 from the pin-state register. A mis-merged output write shows on pin_out in the very next cycle, as a pin outside the mask that flipped, or a masked pin that kept its old level. Enable bits decoded in the wrong layout only show when a shared pin goes high, two edges later. So the bench raises single shared pins against single enable bits on two instances, one per layout.

// File: rtl/gpio_bank_pkg.sv
// Package gpio_bank_pkg
// Shared register selectors and control-bit positions for the GPIO bank.
// Assumes a word-addressed bus with a 3-bit address.
package gpio_bank_pkg;
    localparam int unsigned ADDR_W = 3;

    // Control-bit positions; software relies on these exact positions.
    localparam int unsigned CTRL_RUN_BIT   = 0;
    localparam int unsigned CTRL_RESET_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_OUT  = 3'd2,
        SEL_PINS = 3'd3,
        SEL_IEN  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/gpio_bank_ctrl.sv
// Module gpio_bank_ctrl
// Holds the two-bit bank control register and derives the local clock
// enable, the held clear and the "active" qualifier used by the rest of
// the bank. Assumes wr_ctrl is a single-cycle strobe.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [1:0] wdata,
    output logic [1:0] ctrl_q,
    output logic       run_en,
    output logic       blk_clr,
    output logic       blk_active
);
    // Capture the control word; it is writable in every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    // Decode the run and clear qualifiers from the stored control word.
    always_comb begin
        run_en     = ctrl_q[CTRL_RUN_BIT];
        blk_clr    = ctrl_q[CTRL_RESET_BIT];
        blk_active = run_en && !blk_clr;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Module gpio_bank_regs
// Direction, output-data and interrupt-enable registers. A held clear
// zeroes all three; updates are taken only while the bank is active.
// Output writes merge data under the per-pin mask in the upper half.
module gpio_bank_regs #(
    parameter int unsigned NUM_PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blk_clr,
    input  logic                  blk_active,
    input  logic                  wr_dir,
    input  logic                  wr_out,
    input  logic                  wr_ien,
    input  logic [2*NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0]   dir_q,
    output logic [NUM_PINS-1:0]   out_q,
    output logic [NUM_PINS-1:0]   ien_q
);
    localparam int unsigned MASK_LO = NUM_PINS;

    logic [NUM_PINS-1:0] wr_mask;
    logic [NUM_PINS-1:0] wr_val;
    logic [NUM_PINS-1:0] out_merged;

    // Split the write word and merge new data under the mask.
    always_comb begin
        wr_mask    = wdata[MASK_LO +: NUM_PINS];
        wr_val     = wdata[NUM_PINS-1:0];
        out_merged = (out_q & ~wr_mask) | (wr_val & wr_mask);
    end

    // Direction register: whole-word replace.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_clr) begin
            dir_q <= '0;
        end else if (blk_active && wr_dir) begin
            dir_q <= wr_val;
        end
    end

    // Output-data register: masked update.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_clr) begin
            out_q <= '0;
        end else if (blk_active && wr_out) begin
            out_q <= out_merged;
        end
    end

    // Interrupt-enable register: whole-word replace, all bits stored.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_clr) begin
            ien_q <= '0;
        end else if (blk_active && wr_ien) begin
            ien_q <= wr_val;
        end
    end
endmodule

// File: rtl/gpio_bank_sync.sv
// Module gpio_bank_sync
// Multi-stage synchronizer for the pin inputs. It advances only while
// the local clock enable is set and is cleared by the held clear.
// Assumes STAGES >= 2.
module gpio_bank_sync #(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [NUM_PINS-1:0] d,
    output logic [NUM_PINS-1:0] q
);
    logic [NUM_PINS-1:0] stg [STAGES];

    // Shift the pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else if (en) begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    // The last stage is the synchronized level.
    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_irq.sv
// Module gpio_bank_irq
// Shared interrupt for the upper pins: each pin ANDed with its enable
// bit, the results ORed. PACKED picks the enable-bit layout: bit k for
// pin FIRST+k, or bit n for pin n. Assumes FIRST < NUM_PINS.
module gpio_bank_irq #(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned FIRST    = 8,
    parameter bit          PACKED   = 1'b0
) (
    input  logic                pins_s,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] ien,
    output logic                irq
);
    localparam int unsigned SHARED = NUM_PINS - FIRST;

    logic [SHARED-1:0] hit;

    // One gate per shared pin, enable index chosen by layout.
    for (genvar k = 0; k < SHARED; k++) begin : g_gate
        if (PACKED) begin : g_packed
            assign hit[k] = pin_lvl[FIRST+k] & ien[k];
        end else begin : g_direct
            assign hit[k] = pin_lvl[FIRST+k] & ien[FIRST+k];
        end
    end

    // Merge the gated pins, qualified by the bank-active input.
    assign irq = pins_s && (|hit);
endmodule

// File: rtl/gpio_bank.sv
// Module gpio_bank
// Sixteen-pin GPIO bank: control register, direction, masked output,
// synchronized pin state and a shared interrupt for the upper pins.
// Assumes a single-cycle write strobe and a combinational read port.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS      = 16,
    parameter int unsigned SHARED_FIRST  = 8,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter bit          IRQ_EN_PACKED = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2*NUM_PINS-1:0] bus_wdata,
    output logic [2*NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic                  irq_shared
);
    localparam int unsigned WORD_W = 2 * NUM_PINS;

    logic [1:0]          ctrl_q;
    logic                run_en;
    logic                blk_clr;
    logic                blk_active;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] ien_q;
    logic [NUM_PINS-1:0] pins_s;
    logic                wr_ctrl;
    logic                wr_dir;
    logic                wr_out;
    logic                wr_ien;

    // Decode the write strobe per register.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == SEL_CTRL);
        wr_dir  = bus_wr && (bus_addr == SEL_DIR);
        wr_out  = bus_wr && (bus_addr == SEL_OUT);
        wr_ien  = bus_wr && (bus_addr == SEL_IEN);
    end

    gpio_bank_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata[1:0]),
        .ctrl_q     (ctrl_q),
        .run_en     (run_en),
        .blk_clr    (blk_clr),
        .blk_active (blk_active)
    );

    gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_clr    (blk_clr),
        .blk_active (blk_active),
        .wr_dir     (wr_dir),
        .wr_out     (wr_out),
        .wr_ien     (wr_ien),
        .wdata      (bus_wdata),
        .dir_q      (dir_q),
        .out_q      (out_q),
        .ien_q      (ien_q)
    );

    gpio_bank_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (blk_clr),
        .en    (run_en),
        .d     (pin_in),
        .q     (pins_s)
    );

    gpio_bank_irq #(
        .NUM_PINS (NUM_PINS),
        .FIRST    (SHARED_FIRST),
        .PACKED   (IRQ_EN_PACKED)
    ) u_irq (
        .pins_s  (blk_active),
        .pin_lvl (pins_s),
        .ien     (ien_q),
        .irq     (irq_shared)
    );

    // Release the pins whenever the bank is not active.
    always_comb begin
        pin_oe  = blk_active ? dir_q : '0;
        pin_out = blk_active ? out_q : '0;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            SEL_CTRL: bus_rdata[1:0]          = ctrl_q;
            SEL_DIR:  bus_rdata[NUM_PINS-1:0] = dir_q;
            SEL_OUT:  bus_rdata[NUM_PINS-1:0] = out_q;
            SEL_PINS: bus_rdata[NUM_PINS-1:0] = blk_active ? pins_s : '0;
            SEL_IEN:  bus_rdata[NUM_PINS-1:0] = ien_q;
            default:  bus_rdata               = {WORD_W{1'b0}};
        endcase
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Module gpio_bank_chk
// Property checker for gpio_bank, attached with the bind below.
// Assumes the synchronous active-low reset of the bank.
module gpio_bank_chk #(
    parameter int unsigned NUM_PINS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [2:0]            bus_addr,
    input logic [2*NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic [NUM_PINS-1:0]   pin_out,
    input logic                  irq_shared,
    input logic                  blk_active,
    input logic                  blk_clr,
    input logic [NUM_PINS-1:0]   dir_q,
    input logic [NUM_PINS-1:0]   out_q,
    input logic [NUM_PINS-1:0]   ien_q,
    input logic [NUM_PINS-1:0]   pins_s
);
    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_active |-> (pin_oe == '0 && pin_out == '0 && !irq_shared));

    // R3
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_clr |=> (dir_q == '0 && out_q == '0 && ien_q == '0));

    // R4
    idle_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_active && !blk_clr && bus_wr && bus_addr != 3'd0)
        |=> ($stable(dir_q) && $stable(out_q) && $stable(ien_q)));

    // R5
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_active |-> (pin_oe == dir_q));

    // R6
    write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && blk_active && !$isunknown(out_q))
        |=> (((out_q ^ $past(out_q)) & ~$past(bus_wdata[2*NUM_PINS-1:NUM_PINS])) == '0));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared |-> (blk_active && (|pins_s[NUM_PINS-1:NUM_PINS/2])));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .irq_shared (irq_shared),
    .blk_active (blk_active),
    .blk_clr    (blk_clr),
    .dir_q      (dir_q),
    .out_q      (out_q),
    .ien_q      (ien_q),
    .pins_s     (pins_s)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
// Bench for gpio_bank: one instance per enable-bit layout, a reference
// model in bench variables, directed corners then seeded random traffic.
module test_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [15:0] pin_in = 16'd0;
    logic [31:0] rd_a, rd_b;
    logic [15:0] out_a, out_b, oe_a, oe_b;
    logic        irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;

    logic [1:0]  m_ctrl = 2'd0;
    logic [15:0] m_dir = 16'd0, m_out = 16'd0, m_ien = 16'd0;

    always #2 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pin_in(pin_in),
        .pin_out(out_a), .pin_oe(oe_a), .irq_shared(irq_a));

    gpio_bank #(.IRQ_EN_PACKED(1'b1)) i_gpio_bank_pk (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pin_in),
        .pin_out(out_b), .pin_oe(oe_b), .irq_shared(irq_b));

    function automatic logic exp_irq(input logic [15:0] p, input logic [15:0] en,
                                     input logic packed_l, input logic act);
        logic r = 1'b0;
        for (int k = 0; k < 8; k++) begin
            r = r | (p[8+k] & (packed_l ? en[k] : en[8+k]));
        end
        return r & act;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd0) begin
            m_ctrl = d[1:0];
            if (d[1]) begin m_dir = 0; m_out = 0; m_ien = 0; end
        end else if (m_ctrl == 2'd1) begin
            case (a)
                3'd1: m_dir = d[15:0];
                3'd2: m_out = (m_out & ~d[31:16]) | (d[15:0] & d[31:16]);
                3'd4: m_ien = d[15:0];
                default: ;
            endcase
        end
    endtask

    task automatic rd_both(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, rd_a, exp);
        chk(tag, rd_b, exp);
    endtask

    task automatic check_all(input string ctx);
        logic act = (m_ctrl == 2'd1);
        repeat (3) @(negedge clk);
        #1;
        chk({ctx, " R5 pin_oe"}, {16'd0, oe_a}, {16'd0, act ? m_dir : 16'd0});
        chk({ctx, " R5 pin_oe pk"}, {16'd0, oe_b}, {16'd0, act ? m_dir : 16'd0});
        chk({ctx, " R6 pin_out"}, {16'd0, out_a}, {16'd0, act ? m_out : 16'd0});
        chk({ctx, " R6 pin_out pk"}, {16'd0, out_b}, {16'd0, act ? m_out : 16'd0});
        chk({ctx, " R8 R9 irq direct"}, {31'd0, irq_a}, {31'd0, exp_irq(pin_in, m_ien, 1'b0, act)});
        chk({ctx, " R8 R9 irq packed"}, {31'd0, irq_b}, {31'd0, exp_irq(pin_in, m_ien, 1'b1, act)});
        rd_both({ctx, " R2 ctrl"}, 3'd0, {30'd0, m_ctrl});
        rd_both({ctx, " R5 dir"}, 3'd1, {16'd0, m_dir});
        rd_both({ctx, " R6 out"}, 3'd2, {16'd0, m_out});
        rd_both({ctx, " R7 pins"}, 3'd3, {16'd0, act ? pin_in : 16'd0});
        rd_both({ctx, " R10 ien"}, 3'd4, {16'd0, m_ien});
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1 reset");
        // R4: writes with clock off are dropped
        wr(3'd1, 32'h0000_FFFF);
        check_all("R4 idle write");
        // R2: activate
        wr(3'd0, 32'd1);
        wr(3'd1, 32'h0000_F00F);
        wr(3'd2, 32'hFFFF_A5A5);
        check_all("R2 R5 R6 active");
        // R6: masked update, only bits 7:4 cleared
        wr(3'd2, 32'h00F0_0000);
        check_all("R6 mask");
        chk("R6 mask value", {16'd0, m_out}, 32'h0000_A505);
        // R9: packed bit 0 gates pin 8, direct bit 8 gates pin 8
        pin_in = 16'h0100;
        wr(3'd4, 32'h0000_0001);
        check_all("R9 packed bit0");
        chk("R9 direct irq low", {31'd0, irq_a}, 32'd0);
        chk("R9 packed irq high", {31'd0, irq_b}, 32'd1);
        wr(3'd4, 32'h0000_0100);
        check_all("R9 direct bit8");
        // R8: level follows pin with no acknowledge
        pin_in = 16'h0000;
        check_all("R8 drop");
        // R7: write to pin state and unmapped ignored
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        check_all("R7 ro");
        rd_both("R7 unmapped", 3'd6, 32'd0);
        // R4: clock off keeps contents, releases pins
        pin_in = 16'hFF00;
        wr(3'd0, 32'd0);
        check_all("R4 clock off");
        wr(3'd0, 32'd1);
        check_all("R4 resume");
        // R3: held reset clears and drops writes
        wr(3'd0, 32'd3);
        wr(3'd1, 32'h0000_1234);
        check_all("R3 held");
        wr(3'd0, 32'd1);
        check_all("R3 release");
        wr(3'd1, 32'h0000_00FF);
        wr(3'd0, 32'd2);
        check_all("R3 low power");
        wr(3'd0, 32'd1);
        check_all("R3 after low power");
        // Seeded random traffic
        for (int it = 0; it < 250; it++) begin
            case ($urandom_range(0, 5))
                0: wr(3'd1, {16'd0, 16'($urandom)});
                1: wr(3'd2, $urandom);
                2: wr(3'd4, {16'd0, 16'($urandom)});
                3: pin_in = 16'($urandom);
                4: wr(3'd0, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 3)) : 32'd1);
                default: wr(3'($urandom_range(5, 7)), $urandom);
            endcase
            if (m_ctrl != 2'd1 && $urandom_range(0, 1) == 1) wr(3'd0, 32'd1);
            check_all("random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule